// File: doc/BRIEF.md
# Byte Arithmetic Unit with Status Flag Update

This block is the arithmetic and logic stage of a small 8-bit RISC core. Each accepted request carries an operation code, two byte operands, a 16-bit register-pair operand and the current status byte. The block returns a result, the updated status byte and the number of cycles the operation took. Byte operations finish one cycle after acceptance. The two word operations add or subtract a 6-bit immediate on a register pair and finish two cycles after acceptance.

Each operation changes only its own group of status flags. Every other flag is copied from the incoming status byte. This lets the core chain operations: for example, an increment leaves the carry from an earlier add untouched, and a subtract-with-carry can only clear zero, so multi-byte compares work across several bytes. Results and status stay on the outputs until the next operation completes.

Top module: `alu8_status_unit`

## Requirements
- R1: Operation codes on `op_in` are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 AND, 5 OR, 6 XOR, 7 one's complement, 8 negate, 9 increment, 10 decrement, 11 set-all-ones, 12 word add-immediate, 13 word subtract-immediate. Codes 14 and 15 return result 0 and leave status unchanged. A byte operation accepted at a clock edge presents its result on `res_out[7:0]`, with `res_out[15:8]`=0, and its status after that edge, with a one-cycle `out_valid` pulse and `cyc_out`=1.
- R2: A word operation accepted at an edge raises `busy` for the next cycle, with `out_valid` low. Its result appears after the following edge with `cyc_out`=2. A request presented while `busy` is high is ignored and produces no result.
- R3: Add and add-with-carry (the carry-in is status bit 0) set C to the carry out of bit 7, H to the carry out of bit 3, V to signed overflow, N to bit 7 and Z to result==0.
- R4: Subtract and subtract-with-carry set C to the borrow out of bit 7, H to the borrow out of bit 3, V to signed overflow and N to bit 7. Z is result==0 for subtract. For subtract-with-carry, Z is result==0 AND the old Z.
- R5: AND, OR and XOR set N and Z, clear V, and keep C and H.
- R6: One's complement returns 0xFF minus the operand, sets C to 1 and V to 0, updates N and Z, and keeps H.
- R7: Negate returns 0x00 minus operand A. It sets C when A≠0, V when A=0x80 and H to the borrow out of bit 3, and updates N and Z.
- R8: Increment and decrement update only N, Z, V and S. V is set when increment gives 0x80 or decrement gives 0x7F. C and H are kept.
- R9: Set-all-ones returns 0xFF and passes the status byte through unchanged.
- R10: Word operations on `pair_in` with immediate `b_in[5:0]` give a 16-bit result. They set N to bit 15 and Z to result==0, set C to the carry (add) or borrow (subtract) out of bit 15, and set V to signed overflow. H is kept.
- R11: Status bits are I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0. I and T always pass through. Every operation that updates N also sets S = N XOR V.
- R12: After reset `out_valid`, `busy`, `res_out`, `status_out` and `cyc_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_in | input | 4 | Operation code |
| a_in | input | 8 | First byte operand |
| b_in | input | 8 | Second byte operand or constant; low 6 bits form the word immediate |
| pair_in | input | 16 | Register-pair operand for word operations |
| status_in | input | 8 | Current status byte |
| busy | output | 1 | Second cycle of a word operation in progress |
| out_valid | output | 1 | One-cycle pulse when a result completes |
| res_out | output | 16 | Result; upper byte is zero for byte operations |
| status_out | output | 8 | Updated status byte |
| cyc_out | output | 2 | Cycle count of the completed operation |

## Verification
The bench drives each request on a falling edge. It reads a byte operation's result, status and cycle count on the next falling edge, one rising edge after acceptance. For word operations it first checks, one falling edge after acceptance, that `busy` is high and `out_valid` is low. It reads the result one falling edge later, after the second rising edge. In some word runs the bench presents a conflicting request during the busy cycle. It then confirms that the word result arrives intact and that no further `out_valid` pulse follows on the next falling edge.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_COM  = 4'd7,
    OP_NEG  = 4'd8,
    OP_INC  = 4'd9,
    OP_DEC  = 4'd10,
    OP_SER  = 4'd11,
    OP_WADD = 4'd12,
    OP_WSUB = 4'd13,
    OP_RS14 = 4'd14,
    OP_RS15 = 4'd15
  } alu_op_e;

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
  localparam int FL_T = 6;
  localparam int FL_I = 7;
  localparam int ST_W = 8;
endpackage

// File: rtl/alu8_byte_core.sv
module alu8_byte_core
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e          op,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  input  logic [ST_W-1:0]  st_in,
  output logic [DW-1:0]    res,
  output logic [ST_W-1:0]  st_out
);
  localparam int MSB = DW - 1;
  localparam int HB  = 3;
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};

  logic [DW:0] sum_w, dif_w;
  logic        cin, bin;
  logic        r_h, r_c, r_v, r_z, zero;
  logic        up_h, up_c, up_nzvs;

  always_comb begin
    cin   = (op == OP_ADC) & st_in[FL_C];
    bin   = (op == OP_SBC) & st_in[FL_C];
    sum_w = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    dif_w = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, bin};
    res     = '0;
    r_h     = 1'b0;
    r_c     = 1'b0;
    r_v     = 1'b0;
    up_h    = 1'b0;
    up_c    = 1'b0;
    up_nzvs = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC: begin
        res  = sum_w[MSB:0];
        r_c  = sum_w[DW];
        r_h  = (a[HB] & b[HB]) | (b[HB] & ~res[HB]) | (~res[HB] & a[HB]);
        r_v  = (a[MSB] & b[MSB] & ~res[MSB]) | (~a[MSB] & ~b[MSB] & res[MSB]);
        up_h = 1'b1; up_c = 1'b1; up_nzvs = 1'b1;
      end
      OP_SUB, OP_SBC: begin
        res  = dif_w[MSB:0];
        r_c  = dif_w[DW];
        r_h  = (~a[HB] & b[HB]) | (b[HB] & res[HB]) | (res[HB] & ~a[HB]);
        r_v  = (a[MSB] & ~b[MSB] & ~res[MSB]) | (~a[MSB] & b[MSB] & res[MSB]);
        up_h = 1'b1; up_c = 1'b1; up_nzvs = 1'b1;
      end
      OP_AND: begin res = a & b; up_nzvs = 1'b1; end
      OP_OR:  begin res = a | b; up_nzvs = 1'b1; end
      OP_XOR: begin res = a ^ b; up_nzvs = 1'b1; end
      OP_COM: begin
        res = ~a; r_c = 1'b1; up_c = 1'b1; up_nzvs = 1'b1;
      end
      OP_NEG: begin
        res  = '0 - a;
        r_c  = (res != '0);
        r_h  = res[HB] | a[HB];
        r_v  = (res == MINV);
        up_h = 1'b1; up_c = 1'b1; up_nzvs = 1'b1;
      end
      OP_INC: begin res = a + 1'b1; r_v = (res == MINV); up_nzvs = 1'b1; end
      OP_DEC: begin res = a - 1'b1; r_v = (res == MAXV); up_nzvs = 1'b1; end
      OP_SER: res = '1;
      default: res = '0;
    endcase
    zero = (res == '0);
    r_z  = (op == OP_SBC) ? (zero & st_in[FL_Z]) : zero;
    st_out = st_in;
    if (up_h) st_out[FL_H] = r_h;
    if (up_c) st_out[FL_C] = r_c;
    if (up_nzvs) begin
      st_out[FL_N] = res[MSB];
      st_out[FL_V] = r_v;
      st_out[FL_Z] = r_z;
      st_out[FL_S] = res[MSB] ^ r_v;
    end
  end
endmodule

// File: rtl/alu8_word_unit.sv
module alu8_word_unit
  import alu8_pkg::*;
#(
  parameter int DW   = 8,
  parameter int IMMW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_sub,
  input  logic [2*DW-1:0]   pair,
  input  logic [IMMW-1:0]   imm,
  input  logic [ST_W-1:0]   st_in,
  output logic              busy,
  output logic [2*DW-1:0]   w_res,
  output logic [ST_W-1:0]   w_st
);
  localparam int WW  = 2 * DW;
  localparam int MSB = DW - 1;

  logic            ph_q, ph_d;
  logic            sub_q, cy_q;
  logic [DW-1:0]   lo_q, hi_q;
  logic [ST_W-1:0] st_q;
  logic [DW:0]     lo_step, imm_x;
  logic [DW-1:0]   hi_new;
  logic            p_top, r_top;

  // phase 1: low byte and the carry/borrow into the high byte
  always_comb begin
    imm_x   = {{(DW+1-IMMW){1'b0}}, imm};
    lo_step = is_sub ? ({1'b0, pair[MSB:0]} - imm_x)
                     : ({1'b0, pair[MSB:0]} + imm_x);
    ph_d    = start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  always_ff @(posedge clk) begin
    if (start) begin
      sub_q <= is_sub;
      lo_q  <= lo_step[MSB:0];
      cy_q  <= lo_step[DW];
      hi_q  <= pair[WW-1:DW];
      st_q  <= st_in;
    end
  end

  // phase 2: high byte and the word flags
  always_comb begin
    hi_new = sub_q ? (hi_q - {{(DW-1){1'b0}}, cy_q})
                   : (hi_q + {{(DW-1){1'b0}}, cy_q});
    w_res  = {hi_new, lo_q};
    p_top  = hi_q[MSB];
    r_top  = hi_new[MSB];
    w_st   = st_q;
    w_st[FL_N] = r_top;
    w_st[FL_Z] = (w_res == '0);
    w_st[FL_V] = sub_q ? (p_top & ~r_top) : (~p_top & r_top);
    w_st[FL_C] = sub_q ? (r_top & ~p_top) : (p_top & ~r_top);
    w_st[FL_S] = r_top ^ w_st[FL_V];
  end

  assign busy = ph_q;

  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  a_r2_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
endmodule

// File: rtl/alu8_status_unit.sv
module alu8_status_unit
  import alu8_pkg::*;
#(
  parameter int DW   = 8,
  parameter int IMMW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        op_in,
  input  logic [DW-1:0]     a_in,
  input  logic [DW-1:0]     b_in,
  input  logic [2*DW-1:0]   pair_in,
  input  logic [7:0]        status_in,
  output logic              busy,
  output logic              out_valid,
  output logic [2*DW-1:0]   res_out,
  output logic [7:0]        status_out,
  output logic [1:0]        cyc_out
);
  localparam int WW = 2 * DW;

  alu_op_e         op;
  logic            is_word, acc, w_busy;
  logic [DW-1:0]   b_res;
  logic [ST_W-1:0] b_st, w_st;
  logic [WW-1:0]   w_res;

  logic            vld_q, vld_d;
  logic [WW-1:0]   res_q, res_d;
  logic [ST_W-1:0] st_q, st_d;
  logic [1:0]      cyc_q, cyc_d;

  assign op      = alu_op_e'(op_in);
  assign is_word = (op == OP_WADD) || (op == OP_WSUB);
  assign acc     = in_valid & ~w_busy;

  alu8_byte_core #(.DW(DW)) u_byte (
    .op(op), .a(a_in), .b(b_in), .st_in(status_in),
    .res(b_res), .st_out(b_st)
  );

  alu8_word_unit #(.DW(DW), .IMMW(IMMW)) u_word (
    .clk(clk), .rst_n(rst_n), .start(acc & is_word),
    .is_sub(op == OP_WSUB), .pair(pair_in), .imm(b_in[IMMW-1:0]),
    .st_in(status_in), .busy(w_busy), .w_res(w_res), .w_st(w_st)
  );

  always_comb begin
    vld_d = 1'b0;
    res_d = res_q;
    st_d  = st_q;
    cyc_d = cyc_q;
    if (w_busy) begin
      vld_d = 1'b1;
      res_d = w_res;
      st_d  = w_st;
      cyc_d = 2'd2;
    end else if (acc && !is_word) begin
      vld_d = 1'b1;
      res_d = {{DW{1'b0}}, b_res};
      st_d  = b_st;
      cyc_d = 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      st_q  <= '0;
      cyc_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
      st_q  <= st_d;
      cyc_q <= cyc_d;
    end
  end

  assign busy       = w_busy;
  assign out_valid  = vld_q;
  assign res_out    = res_q;
  assign status_out = st_q;
  assign cyc_out    = cyc_q;

  a_r1_byte_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !is_word) |=> (out_valid && cyc_out == 2'd1));
  a_r2_word_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_word) |=> (!out_valid ##1 (out_valid && cyc_out == 2'd2)));
  a_r5_logic_keeps_ch: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=>
      (status_out[FL_C] == $past(status_in[FL_C]) &&
       status_out[FL_H] == $past(status_in[FL_H]) && !status_out[FL_V]));
  a_r9_ser_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_SER) |=>
      (res_out == {{DW{1'b0}}, {DW{1'b1}}} && status_out == $past(status_in)));
  a_r11_it_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !is_word) |=> (status_out[FL_I] == $past(status_in[FL_I]) &&
                           status_out[FL_T] == $past(status_in[FL_T])));
endmodule

// File: tb/alu8_status_unit_bench.sv
`timescale 1ns/1ps
module alu8_status_unit_bench;
  logic        clk, rst_n, in_valid;
  logic [3:0]  op_in;
  logic [7:0]  a_in, b_in, status_in;
  logic [15:0] pair_in;
  logic        busy, out_valid;
  logic [15:0] res_out;
  logic [7:0]  status_out;
  logic [1:0]  cyc_out;
  int total = 0;
  int bad   = 0;

  alu8_status_unit u_alu8_status_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_in(op_in),
    .a_in(a_in), .b_in(b_in), .pair_in(pair_in), .status_in(status_in),
    .busy(busy), .out_valid(out_valid), .res_out(res_out),
    .status_out(status_out), .cyc_out(cyc_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:   return "R3";
      4'd2, 4'd3:   return "R4";
      4'd4, 4'd5, 4'd6: return "R5";
      4'd7:         return "R6";
      4'd8:         return "R7";
      4'd9, 4'd10:  return "R8";
      4'd11:        return "R9";
      4'd12, 4'd13: return "R10";
      default:      return "R1";
    endcase
  endfunction

  function automatic int sx8(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // returns {cycles[1:0], result[15:0], status[7:0]}
  function automatic logic [25:0] model(input logic [3:0] op, input logic [7:0] a,
      input logic [7:0] b, input logic [15:0] p, input logic [7:0] st);
    int ai, bi, c, r, sr, k, pi;
    logic [7:0]  r8, s;
    logic [15:0] r16;
    bit v, z, nzv;
    ai = a; bi = b; c = st[0]; s = st; r8 = 8'h00; v = 0; nzv = 1;
    case (op)
      4'd0, 4'd1: begin
        if (op == 4'd0) c = 0;
        r = ai + bi + c; r8 = 8'(r); sr = sx8(ai) + sx8(bi) + c;
        s[0] = r > 255; s[5] = ((ai & 15) + (bi & 15) + c) > 15;
        v = (sr > 127) || (sr < -128);
      end
      4'd2, 4'd3: begin
        if (op == 4'd2) c = 0;
        r = ai - bi - c; r8 = 8'(r); sr = sx8(ai) - sx8(bi) - c;
        s[0] = ai < bi + c; s[5] = (ai & 15) < ((bi & 15) + c);
        v = (sr > 127) || (sr < -128);
      end
      4'd4: r8 = a & b;
      4'd5: r8 = a | b;
      4'd6: r8 = a ^ b;
      4'd7: begin r8 = 8'(255 - ai); s[0] = 1; end
      4'd8: begin r8 = 8'(256 - ai); s[0] = ai != 0; s[5] = (ai & 15) != 0; v = ai == 128; end
      4'd9:  begin r8 = 8'(ai + 1); v = ai == 127; end
      4'd10: begin r8 = 8'(ai + 255); v = ai == 128; end
      4'd11: begin r8 = 8'hFF; nzv = 0; end
      4'd12, 4'd13: begin
        k = bi & 63; pi = p;
        if (op == 4'd12) begin
          r = pi + k; r16 = 16'(r); s[0] = r > 65535;
          v = (pi < 32768) && (r16 >= 16'h8000);
        end else begin
          r = pi - k; r16 = 16'(r + 65536); s[0] = k > pi;
          v = (pi >= 32768) && (r16 < 16'h8000);
        end
        s[2] = r16[15]; s[1] = (r16 == 16'h0); s[3] = v; s[4] = r16[15] ^ v;
        return {2'd2, r16, s};
      end
      default: nzv = 0;
    endcase
    if (nzv) begin
      z = (r8 == 8'h00);
      if (op == 4'd3) z = z && st[1];
      s[2] = r8[7]; s[1] = z; s[3] = v; s[4] = r8[7] ^ v;
    end
    return {2'd1, 8'h00, r8, s};
  endfunction

  task automatic run_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic [15:0] p, input logic [7:0] st, input bit poke);
    logic [25:0] e;
    string rq;
    e  = model(op, a, b, p, st);
    rq = req_of(op);
    @(negedge clk);
    op_in = op; a_in = a; b_in = b; pair_in = p; status_in = st; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (op == 4'd12 || op == 4'd13) begin
      check("R2", "busy mid-word", 32'(busy), 32'd1);
      check("R2", "no early valid", 32'(out_valid), 32'd0);
      if (poke) begin
        op_in = 4'd11; status_in = ~st; in_valid = 1'b1;
      end
      @(negedge clk);
      in_valid = 1'b0;
    end
    check(rq, "out_valid", 32'(out_valid), 32'd1);
    check(rq, "result", 32'(res_out), 32'(e[23:8]));
    check(rq, "status", 32'(status_out), 32'(e[7:0]));
    check(rq, "cycles", 32'(cyc_out), 32'(e[25:24]));
    if (poke) begin
      @(negedge clk);
      check("R2", "ignored request gave no pulse", 32'(out_valid), 32'd0);
      check("R2", "result held", 32'(res_out), 32'(e[23:8]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0; in_valid = 1'b0; op_in = '0; a_in = '0; b_in = '0;
    pair_in = '0; status_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12", "out_valid", 32'(out_valid), 32'd0);
    check("R12", "busy", 32'(busy), 32'd0);
    check("R12", "res_out", 32'(res_out), 32'd0);
    check("R12", "status_out", 32'(status_out), 32'd0);
    check("R12", "cyc_out", 32'(cyc_out), 32'd0);
    // directed corners
    run_op(4'd0, 8'hFF, 8'h01, 16'h0, 8'h00, 0);  // R3 carry, zero, half
    run_op(4'd0, 8'h7F, 8'h01, 16'h0, 8'hC0, 0);  // R3 overflow, R11 I/T kept
    run_op(4'd1, 8'h0F, 8'h00, 16'h0, 8'h01, 0);  // R3 carry-in
    run_op(4'd2, 8'h00, 8'h01, 16'h0, 8'h00, 0);  // R4 borrow
    run_op(4'd3, 8'h10, 8'h10, 16'h0, 8'h00, 0);  // R4 Z stays clear
    run_op(4'd3, 8'h10, 8'h10, 16'h0, 8'h02, 0);  // R4 Z kept set
    run_op(4'd4, 8'hF0, 8'h0F, 16'h0, 8'h2B, 0);  // R5 keep C,H
    run_op(4'd7, 8'h00, 8'h00, 16'h0, 8'h20, 0);  // R6
    run_op(4'd8, 8'h80, 8'h00, 16'h0, 8'h00, 0);  // R7 overflow
    run_op(4'd8, 8'h00, 8'h00, 16'h0, 8'h21, 0);  // R7 zero
    run_op(4'd9, 8'h7F, 8'h00, 16'h0, 8'h21, 0);  // R8 C,H kept
    run_op(4'd10, 8'h80, 8'h00, 16'h0, 8'h01, 0); // R8
    run_op(4'd11, 8'h12, 8'h34, 16'h0, 8'h5A, 0); // R9
    run_op(4'd14, 8'h12, 8'h34, 16'h0, 8'hA5, 0); // R1 unused code
    run_op(4'd12, 8'h00, 8'h01, 16'hFFFF, 8'h20, 0); // R10 wrap
    run_op(4'd12, 8'h00, 8'h3F, 16'h7FFF, 8'h00, 1); // R10 overflow, R2 ignore
    run_op(4'd13, 8'h00, 8'h01, 16'h0000, 8'hC0, 0); // R10 borrow
    run_op(4'd13, 8'h00, 8'h01, 16'h8000, 8'h00, 1); // R10 overflow, R2 ignore
    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [3:0] rop;
      rop = 4'($urandom_range(0, 15));
      run_op(rop, 8'($urandom), 8'($urandom), 16'($urandom), 8'($urandom),
             ($urandom_range(0, 3) == 0));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule